// File: doc/BRIEF.md
# Pulse-Count Motion Run Controller

This block decides how long a motor driver keeps emitting drive pulses. A host writes one command word holding a pulse count and a direction bit. An accepted write with a non-zero count starts a run. The block then counts the period-complete strobes that the waveform generator raises, one for each finished drive period. It ends the run on the strobe that completes the requested number, so the driver never emits a partial pulse.

A write with a zero count aborts any run at once and pulls the driver outputs to ground. Holding the active-low power-down input low has the same effect, and the block ignores writes while it is held low. The direction bit is captured when the word is written and stays fixed until the next accepted write. A done flag reports that a run ended normally rather than through an abort.

Top module: `pulse_run_ctrl`

## Requirements
- R1: After reset, run_en is 0, force_low is 1, done is 0 and dir is 0.
- R2: An accepted write (wr_en high while pd_n is high) whose count field wr_data[10:0] is non-zero sets run_en to 1 and force_low to 0 from the next cycle.
- R3: While run_en is 1, each cycle with period_done high adds one pulse. run_en falls, and force_low rises, in the cycle after the strobe that completes the written count. Until then run_en stays high.
- R4: The count field is 11 bits wide, so the longest run is 2047 pulses, and that run ends exactly on the 2047th strobe.
- R5: An accepted write with a count field of zero clears run_en and sets force_low from the next cycle, whether or not a run is in progress, and it does not set done.
- R6: While pd_n is low, run_en is 0, force_low is 1 and done is 0 from the next cycle. Writes are ignored, and the block stays idle after pd_n returns high until the next accepted write.
- R7: The direction bit wr_data[11] is copied to dir on every accepted write and holds its value until the next accepted write.
- R8: wr_data[15:12] has no effect on any output.
- R9: done rises in the same cycle that a run ends through R3, and it clears on the next accepted write.
- R10: When an accepted write and a period_done strobe fall in the same cycle, the write wins. The strobe is not counted, and the new run needs its full count of later strobes.
- R11: A non-zero write during a run restarts counting from zero against the new count.
- R12: A period_done strobe while run_en is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_n | input | 1 | Power-down, active low |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 16 | Command word: count [10:0], direction [11], [15:12] ignored |
| period_done | input | 1 | One-cycle strobe for each completed drive period |
| run_en | output | 1 | The driver may emit drive periods |
| dir | output | 1 | Latched direction of motion |
| force_low | output | 1 | Hold every driver output at ground |
| done | output | 1 | The last run ended normally |

## Verification
Two events can land in the same cycle: a command write and the period strobe that the counter is waiting for. This happens in the worst case when the write arrives on the final strobe of a run. Directed cases put a write on the same cycle as a strobe, both mid-run and on the terminal strobe. The random phase raises strobes on about half of all cycles and writes on a few percent, so such collisions happen many times over. In each case the bench expects the write to win: done stays low, and the new run still needs its full number of later strobes before run_en falls.

// File: rtl/prc_pkg.sv
package prc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } run_state_e;

   // decoded command for one cycle
   typedef struct packed {
      logic accept;   // write taken (power is up)
      logic start;    // accepted with non-zero count
      logic abort;    // zero-count write or power-down
      logic dir_bit;  // direction carried by the write
   } run_cmd_t;

endpackage

// File: rtl/prc_cmd_decode.sv
module prc_cmd_decode
   import prc_pkg::*;
#(
   parameter int CNT_W   = 11,
   parameter int REG_W   = 16,
   parameter int DIR_POS = 11
) (
   input  logic             pd_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output run_cmd_t         cmd,
   output logic [CNT_W-1:0] target
);

   logic             accept;
   logic             zero_cnt;
   logic [CNT_W-1:0] field;

   assign field    = wr_data[CNT_W-1:0];
   assign zero_cnt = (field == '0);
   assign accept   = wr_en & pd_n;

   always_comb begin
      cmd.accept  = accept;
      cmd.start   = accept & ~zero_cnt;
      cmd.abort   = (accept & zero_cnt) | ~pd_n;
      cmd.dir_bit = wr_data[DIR_POS];
   end

   assign target = field;

endmodule

// File: rtl/prc_pulse_counter.sv
module prc_pulse_counter #(
   parameter int CNT_W      = 11,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic             load,
   input  logic [CNT_W-1:0] target_in,
   input  logic             tick,
   output logic             last
);

   generate
      if (COUNT_DOWN) begin : g_down
         // remaining pulses; final tick when one is left
         logic [CNT_W-1:0] rem_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rem_q <= '0;
            end else if (!pd_n) begin
               rem_q <= '0;
            end else if (load) begin
               rem_q <= target_in;
            end else if (tick) begin
               rem_q <= rem_q - 1'b1;
            end
         end

         assign last = tick && (rem_q == CNT_W'(1));
      end else begin : g_up
         // pulses issued so far against the held target
         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] tgt_q;
         logic [CNT_W:0]   cnt_inc;

         assign cnt_inc = {1'b0, cnt_q} + 1'b1;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               tgt_q <= '0;
            end else if (!pd_n) begin
               cnt_q <= '0;
               tgt_q <= '0;
            end else if (load) begin
               cnt_q <= '0;
               tgt_q <= target_in;
            end else if (tick) begin
               cnt_q <= cnt_inc[CNT_W-1:0];
            end
         end

         assign last = tick && (cnt_inc == {1'b0, tgt_q});
      end
   endgenerate

endmodule

// File: rtl/prc_run_fsm.sv
module prc_run_fsm
   import prc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  run_cmd_t cmd,
   input  logic     last,
   output logic     run_en,
   output logic     dir,
   output logic     force_low,
   output logic     done
);

   run_state_e state_q, state_d;
   logic       run_q, off_q, dir_q;

   always_comb begin
      state_d = state_q;
      if (cmd.abort) begin
         state_d = ST_IDLE;
      end else if (cmd.start) begin
         state_d = ST_RUN;
      end else if (last && state_q == ST_RUN) begin
         state_d = ST_DONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         run_q   <= 1'b0;
         off_q   <= 1'b1;
         dir_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         run_q   <= (state_d == ST_RUN);
         off_q   <= (state_d != ST_RUN);
         if (cmd.accept) begin
            dir_q <= cmd.dir_bit;
         end
      end
   end

   assign run_en    = run_q;
   assign force_low = off_q;
   assign dir       = dir_q;
   assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/pulse_run_ctrl.sv
module pulse_run_ctrl
   import prc_pkg::*;
#(
   parameter int CNT_W      = 11,
   parameter int REG_W      = 16,
   parameter int DIR_POS    = 11,
   parameter bit COUNT_DOWN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             period_done,
   output logic             run_en,
   output logic             dir,
   output logic             force_low,
   output logic             done
);

   localparam int MAX_PULSES = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
         $error("pulse_run_ctrl: CNT_W out of range");
      end
      if (DIR_POS < CNT_W || DIR_POS >= REG_W) begin : g_bad_dir
         $error("pulse_run_ctrl: DIR_POS must sit above the count field inside the word");
      end
      if (MAX_PULSES < 1) begin : g_bad_max
         $error("pulse_run_ctrl: empty count range");
      end
   endgenerate

   run_cmd_t         cmd;
   logic [CNT_W-1:0] target;
   logic             tick;
   logic             last;
   logic             run_int;

   prc_cmd_decode #(
      .CNT_W   (CNT_W),
      .REG_W   (REG_W),
      .DIR_POS (DIR_POS)
   ) u_dec (
      .pd_n    (pd_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .cmd     (cmd),
      .target  (target)
   );

   // a write in the same cycle takes precedence over the strobe
   assign tick = period_done & run_int & ~cmd.accept & pd_n;

   prc_pulse_counter #(
      .CNT_W      (CNT_W),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_n      (pd_n),
      .load      (cmd.accept),
      .target_in (target),
      .tick      (tick),
      .last      (last)
   );

   prc_run_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .last      (last),
      .run_en    (run_int),
      .dir       (dir),
      .force_low (force_low),
      .done      (done)
   );

   assign run_en = run_int;

endmodule

// File: rtl/prc_checker.sv
module prc_checker #(
   parameter int CNT_W   = 11,
   parameter int REG_W   = 16,
   parameter int DIR_POS = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pd_n,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic             period_done,
   input logic             run_en,
   input logic             dir,
   input logic             force_low,
   input logic             done
);

   logic acc;
   logic nz;
   assign acc = wr_en & pd_n;
   assign nz  = (wr_data[CNT_W-1:0] != '0);

   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && nz) |=> (run_en && !force_low));

   a_r5_zero_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !nz) |=> (!run_en && force_low && !done));

   a_r6_power_down: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> (!run_en && force_low && !done));

   a_r7_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(dir));

   a_r7_dir_capture: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (dir == $past(wr_data[DIR_POS])));

   a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !period_done && pd_n && !wr_en) |=> run_en);

   a_r9_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !done);

   a_r9_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(run_en) && $past(period_done)));

   a_r12_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !acc) |=> !run_en);

endmodule

bind pulse_run_ctrl prc_checker #(
   .CNT_W   (CNT_W),
   .REG_W   (REG_W),
   .DIR_POS (DIR_POS)
) u_prc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pd_n        (pd_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .period_done (period_done),
   .run_en      (run_en),
   .dir         (dir),
   .force_low   (force_low),
   .done        (done)
);

// File: tb/test_pulse_run_ctrl.sv
`timescale 1ns/1ps
module test_pulse_run_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pd_n = 1'b1;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        period_done = 1'b0;
   logic        run_en, dir, force_low, done;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic        m_run = 1'b0, m_dir = 1'b0, m_done = 1'b0;
   int          m_cnt = 0, m_tgt = 0;

   always #4 clk = ~clk;

   pulse_run_ctrl i_pulse_run_ctrl (
      .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .wr_en(wr_en), .wr_data(wr_data),
      .period_done(period_done), .run_en(run_en), .dir(dir),
      .force_low(force_low), .done(done)
   );

   function automatic logic [15:0] word(input int cnt, input bit d, input logic [3:0] junk);
      return {junk, d, cnt[10:0]};
   endfunction

   task automatic model_step();
      if (!pd_n) begin
         m_run = 0; m_done = 0; m_cnt = 0; m_tgt = 0;
      end else if (wr_en) begin
         m_dir = wr_data[11]; m_tgt = int'(wr_data[10:0]);
         m_cnt = 0; m_done = 0; m_run = (m_tgt != 0);
      end else if (m_run && period_done) begin
         m_cnt++;
         if (m_cnt == m_tgt) begin
            m_run = 0; m_done = 1;
         end
      end
   endtask

   task automatic check(input string tag);
      checks++;
      if (run_en !== m_run || force_low !== !m_run || done !== m_done || dir !== m_dir) begin
         fails++;
         $display("FAIL %s: run_en=%b force_low=%b done=%b dir=%b expected %b %b %b %b",
                  tag, run_en, force_low, done, dir, m_run, !m_run, m_done, m_dir);
      end
   endtask

   // one clock: drive at negedge, model at posedge, check at next negedge
   task automatic cyc(input bit p, input bit we, input logic [15:0] wd, input bit pdn, input string tag);
      period_done = p; wr_en = we; wr_data = wd; pd_n = pdn;
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(input int n, input bit p, input string tag);
      for (int i = 0; i < n; i++) cyc(p, 1'b0, 16'h0, 1'b1, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 reset values");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      idle(4, 1'b1, "R12 idle strobes");

      // R2 / R3 / R7: run of 3 with direction 1, gaps between strobes
      cyc(1'b0, 1'b1, word(3, 1'b1, 4'h0), 1'b1, "R2 start");
      cyc(1'b1, 1'b0, 16'h0, 1'b1, "R3 strobe 1");
      idle(2, 1'b0, "R3 gap");
      cyc(1'b1, 1'b0, 16'h0, 1'b1, "R3 strobe 2");
      cyc(1'b1, 1'b0, 16'h0, 1'b1, "R3 strobe 3 ends, R9 done");
      idle(3, 1'b1, "R12 strobes after finish");
      cyc(1'b0, 1'b1, word(1, 1'b0, 4'h0), 1'b1, "R9 done cleared by write, R7 dir");
      cyc(1'b1, 1'b0, 16'h0, 1'b1, "R3 single pulse run");

      // R8: upper bits ignored
      cyc(1'b0, 1'b1, word(2, 1'b0, 4'hF), 1'b1, "R8 upper bits");
      idle(2, 1'b1, "R8 run of two");

      // R5: zero write aborts mid run
      cyc(1'b0, 1'b1, word(5, 1'b1, 4'h0), 1'b1, "R2 start 5");
      idle(2, 1'b1, "R3 partial");
      cyc(1'b0, 1'b1, word(0, 1'b0, 4'h0), 1'b1, "R5 zero abort");
      idle(3, 1'b1, "R5 stays stopped");

      // R6: power-down during a run, writes ignored
      cyc(1'b0, 1'b1, word(6, 1'b1, 4'h0), 1'b1, "R2 start 6");
      cyc(1'b1, 1'b0, 16'h0, 1'b1, "R3 strobe");
      cyc(1'b0, 1'b0, 16'h0, 1'b0, "R6 power-down");
      cyc(1'b1, 1'b1, word(9, 1'b0, 4'h0), 1'b0, "R6 write ignored");
      cyc(1'b1, 1'b0, 16'h0, 1'b0, "R6 held");
      idle(3, 1'b1, "R6 idle after release");

      // R10: write on the same cycle as a strobe, including the terminal strobe
      cyc(1'b0, 1'b1, word(2, 1'b0, 4'h0), 1'b1, "R2 start 2");
      cyc(1'b1, 1'b0, 16'h0, 1'b1, "R3 strobe 1");
      cyc(1'b1, 1'b1, word(4, 1'b1, 4'h0), 1'b1, "R10 write wins over final strobe");
      idle(3, 1'b1, "R10 three of four");
      cyc(1'b1, 1'b0, 16'h0, 1'b1, "R10 fourth ends run");

      // R11: restart mid run with new count
      cyc(1'b0, 1'b1, word(5, 1'b0, 4'h0), 1'b1, "R2 start 5");
      idle(3, 1'b1, "R11 partial");
      cyc(1'b0, 1'b1, word(2, 1'b1, 4'h0), 1'b1, "R11 restart 2");
      idle(2, 1'b1, "R11 new run ends");

      // R4: maximum run length
      cyc(1'b0, 1'b1, word(2047, 1'b0, 4'h0), 1'b1, "R4 start max");
      idle(2047, 1'b1, "R4 max run");
      idle(2, 1'b1, "R4 after max");

      // random phase
      for (int i = 0; i < 6000; i++) begin
         bit p, we, pdn;
         logic [15:0] wd;
         p   = ($urandom % 2) == 0;
         we  = ($urandom % 25) == 0;
         pdn = ($urandom % 80) != 0;
         wd  = $urandom;
         if (($urandom % 4) != 0) wd[10:0] = 11'($urandom % 9);
         cyc(p, we, wd, pdn, "R3/R10 random");
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule